// File: doc/BRIEF.md
# Dual-Line Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them on two processor lines: a normal interrupt line and a fast interrupt line. Each line has its own enable mask, and a line is raised whenever any active source is also enabled in that line's mask. The two masks never share state, so one source can be routed to either line, to both, or to neither.

Software changes a mask through a pair of addresses, one that sets the written one-bits and one that clears them. No read-modify-write is needed, so two software agents can each change their own bits without a race. Software can also raise source 0 by itself through a soft-interrupt flag, which is ORed with source input 0. Status reads give the raw level and, for each line, the level ANDed with that line's mask. Both line outputs are registered.

Top module: `dual_intc`

## Requirements
- R1: Reading offset 0x04 or 0x24 returns the level vector: `src_level` with bit 0 ORed with the soft-interrupt flag.
- R2: `irq_out` is high one clock after the level ANDed with the normal-line mask is nonzero, and low one clock after it becomes zero.
- R3: `fiq_out` is high one clock after the level ANDed with the fast-line mask is nonzero, and low one clock after it becomes zero.
- R4: A write to 0x08 (normal line) or 0x28 (fast line) ORs the written data into that line's mask. Reading the same offset returns the mask.
- R5: A write to 0x0C (normal line) or 0x2C (fast line) clears the mask bits that are one in the written data. All other mask bits are left unchanged.
- R6: Reading 0x00 returns the level ANDed with the normal-line mask. Reading 0x20 returns the level ANDed with the fast-line mask.
- R7: A write to 0x10 with data bit 0 set raises the soft-interrupt flag. A write to 0x14 with data bit 0 set lowers it. Reading 0x10 returns level bit 0 in bit 0 and zero in bits 31..1.
- R8: While `rst` is high, both masks and the soft flag are cleared and both outputs are low.
- R9: Writes to 0x00, 0x04, 0x20, 0x24 and to unused offsets change no state. Reads of 0x0C, 0x14, 0x2C and of unused offsets return zero.
- R10: A mask write for one line leaves the other line's mask and output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_level | input | 32 | Level-sensitive interrupt sources |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Normal interrupt line, registered |
| fiq_out | output | 1 | Fast interrupt line, registered |

## Verification
Read data depends combinationally on the current level and on the registered masks. The bench therefore samples a read just after the falling edge that follows the write's rising edge, and at that point it expects the updated mask. The line outputs pass through one more register, so a mask or soft-flag write takes effect on the lines one rising edge after the write edge. A source change made at a falling edge shows on the lines at the very next rising edge. The bench first checks that the output has not yet changed at the falling edge right after the write, and only then checks the new value one cycle later.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int N_LINES = 2;
    localparam int LINE_IRQ = 0;
    localparam int LINE_FIQ = 1;

    localparam logic [ADDR_W-1:0] OFF_IRQ_STAT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_IRQ_RAW   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_IRQ_ENSET = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_IRQ_ENCLR = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_SOFT_SET  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_SOFT_CLR  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_FIQ_STAT  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_FIQ_RAW   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_FIQ_ENSET = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_FIQ_ENCLR = 8'h2C;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_IRQ_STAT,
        RG_IRQ_RAW,
        RG_IRQ_ENSET,
        RG_IRQ_ENCLR,
        RG_SOFT_SET,
        RG_SOFT_CLR,
        RG_FIQ_STAT,
        RG_FIQ_RAW,
        RG_FIQ_ENSET,
        RG_FIQ_ENCLR
    } reg_sel_e;

    typedef struct packed {
        logic set;
        logic clr;
    } mask_cmd_t;

    typedef struct packed {
        mask_cmd_t [N_LINES-1:0] mask;
        logic                    soft_set;
        logic                    soft_clr;
    } wr_cmd_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_IRQ_STAT:  s = RG_IRQ_STAT;
            OFF_IRQ_RAW:   s = RG_IRQ_RAW;
            OFF_IRQ_ENSET: s = RG_IRQ_ENSET;
            OFF_IRQ_ENCLR: s = RG_IRQ_ENCLR;
            OFF_SOFT_SET:  s = RG_SOFT_SET;
            OFF_SOFT_CLR:  s = RG_SOFT_CLR;
            OFF_FIQ_STAT:  s = RG_FIQ_STAT;
            OFF_FIQ_RAW:   s = RG_FIQ_RAW;
            OFF_FIQ_ENSET: s = RG_FIQ_ENSET;
            OFF_FIQ_ENCLR: s = RG_FIQ_ENCLR;
            default:       s = RG_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_write_target(input logic [ADDR_W-1:0] a);
        return (a == OFF_IRQ_ENSET) || (a == OFF_IRQ_ENCLR) ||
               (a == OFF_FIQ_ENSET) || (a == OFF_FIQ_ENCLR) ||
               (a == OFF_SOFT_SET)  || (a == OFF_SOFT_CLR);
    endfunction

endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
    import intc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  mask_cmd_t       cmd,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    mask
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (cmd.set) begin
            mask_q <= mask_q | wdata;
        end else if (cmd.clr) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    assign mask = mask_q;

endmodule

// File: rtl/intc_line_drv.sv
module intc_line_drv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] mask,
    output logic         line
);

    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
        end else begin
            line_q <= |(level & mask);
        end
    end

    assign line = line_q;

endmodule

// File: rtl/intc_bus_if.sv
module intc_bus_if
    import intc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr_en,
    input  logic [N_SRC-1:0]              level,
    input  logic [N_LINES-1:0][N_SRC-1:0] masks,
    output wr_cmd_t                       cmd,
    output logic [DATA_W-1:0]             rdata
);

    reg_sel_e sel;

    assign sel = decode_offset(bus_addr);

    always_comb begin
        cmd = '0;
        if (bus_wr_en) begin
            case (sel)
                RG_IRQ_ENSET: cmd.mask[LINE_IRQ].set = 1'b1;
                RG_IRQ_ENCLR: cmd.mask[LINE_IRQ].clr = 1'b1;
                RG_FIQ_ENSET: cmd.mask[LINE_FIQ].set = 1'b1;
                RG_FIQ_ENCLR: cmd.mask[LINE_FIQ].clr = 1'b1;
                RG_SOFT_SET:  cmd.soft_set = 1'b1;
                RG_SOFT_CLR:  cmd.soft_clr = 1'b1;
                default:      cmd = '0;
            endcase
        end
    end

    always_comb begin
        case (sel)
            RG_IRQ_STAT:  rdata = DATA_W'(level & masks[LINE_IRQ]);
            RG_IRQ_RAW:   rdata = DATA_W'(level);
            RG_IRQ_ENSET: rdata = DATA_W'(masks[LINE_IRQ]);
            RG_SOFT_SET:  rdata = DATA_W'(level[0]);
            RG_FIQ_STAT:  rdata = DATA_W'(level & masks[LINE_FIQ]);
            RG_FIQ_RAW:   rdata = DATA_W'(level);
            RG_FIQ_ENSET: rdata = DATA_W'(masks[LINE_FIQ]);
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/dual_intc.sv
module dual_intc
    import intc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_SRC-1:0]     src_level,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_out,
    output logic                 fiq_out
);

    wr_cmd_t                       cmd;
    logic                          soft_q;
    logic [N_SRC-1:0]              level;
    logic [N_LINES-1:0][N_SRC-1:0] masks;
    logic [N_LINES-1:0]            lines;

    // Soft-interrupt flag, merged into source 0
    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q <= 1'b0;
        end else if (cmd.soft_set && bus_wdata[0]) begin
            soft_q <= 1'b1;
        end else if (cmd.soft_clr && bus_wdata[0]) begin
            soft_q <= 1'b0;
        end
    end

    assign level = src_level | {{(N_SRC-1){1'b0}}, soft_q};

    intc_bus_if #(.N_SRC(N_SRC)) u_bus (
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .level     (level),
        .masks     (masks),
        .cmd       (cmd),
        .rdata     (bus_rdata)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        intc_mask_reg #(.W(N_SRC)) u_mask (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd.mask[g]),
            .wdata (bus_wdata[N_SRC-1:0]),
            .mask  (masks[g])
        );
        intc_line_drv #(.W(N_SRC)) u_drv (
            .clk   (clk),
            .rst   (rst),
            .level (level),
            .mask  (masks[g]),
            .line  (lines[g])
        );
    end

    assign irq_out = lines[LINE_IRQ];
    assign fiq_out = lines[LINE_FIQ];

endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          bus_wr_en,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic                          irq_out,
    input logic                          fiq_out,
    input logic [N_SRC-1:0]              level,
    input logic [N_LINES-1:0][N_SRC-1:0] masks,
    input logic                          soft_q
);

    assert_irq_line_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_out == (|($past(level) & $past(masks[LINE_IRQ]))));

    assert_fiq_line_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> fiq_out == (|($past(level) & $past(masks[LINE_FIQ]))));

    assert_irq_enset_R4: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && bus_addr == OFF_IRQ_ENSET |=>
        masks[LINE_IRQ] == ($past(masks[LINE_IRQ]) | $past(bus_wdata[N_SRC-1:0])));

    assert_fiq_enset_R4: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && bus_addr == OFF_FIQ_ENSET |=>
        masks[LINE_FIQ] == ($past(masks[LINE_FIQ]) | $past(bus_wdata[N_SRC-1:0])));

    assert_irq_enclr_R5: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && bus_addr == OFF_IRQ_ENCLR |=>
        masks[LINE_IRQ] == ($past(masks[LINE_IRQ]) & ~$past(bus_wdata[N_SRC-1:0])));

    assert_fiq_enclr_R5: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && bus_addr == OFF_FIQ_ENCLR |=>
        masks[LINE_FIQ] == ($past(masks[LINE_FIQ]) & ~$past(bus_wdata[N_SRC-1:0])));

    assert_irq_status_R6: assert property (@(posedge clk) disable iff (rst)
        bus_addr == OFF_IRQ_STAT |-> bus_rdata == DATA_W'(level & masks[LINE_IRQ]));

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> masks == '0 && !soft_q && !irq_out && !fiq_out);

    assert_ignored_write_R9: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && !is_write_target(bus_addr) |=> $stable(masks) && $stable(soft_q));

    assert_unused_read_R9: assert property (@(posedge clk) disable iff (rst)
        decode_offset(bus_addr) == RG_NONE |-> bus_rdata == '0);

endmodule

bind dual_intc intc_checker #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .level     (level),
    .masks     (masks),
    .soft_q    (soft_q)
);

// File: tb/dual_intc_tb.sv
`timescale 1ns/1ps
module dual_intc_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] src_level;
    logic [7:0]  bus_addr;
    logic        bus_wr_en;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic        fiq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dual_intc u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_level (src_level),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .fiq_out   (fiq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr_en = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_wdata = '0;
        bus_addr  = 8'hFC;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'hFC;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        src_level = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        #1;
        check("R8 irq_out in reset", 32'(irq_out), 0);
        check("R8 fiq_out in reset", 32'(fiq_out), 0);
        rd(8'h08, d); check("R8 irq mask after reset", d, 0);
        rd(8'h28, d); check("R8 fiq mask after reset", d, 0);
        src_level = '0;
        rd(8'h10, d); check("R8 soft flag after reset", d, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_raw();
        logic [31:0] d;
        src_level = 32'hA5A5_0F0E;
        rd(8'h04, d); check("R1 raw at 0x04", d, 32'hA5A5_0F0E);
        rd(8'h24, d); check("R1 raw at 0x24", d, 32'hA5A5_0F0E);
        step();
        check("R2 no irq with empty mask", 32'(irq_out), 0);
        src_level = '0;
    endtask

    task automatic t_irq();
        logic [31:0] d;
        src_level = 32'h0000_0100;
        wr(8'h08, 32'h0000_0100);
        rd(8'h08, d); check("R4 irq mask set", d, 32'h0000_0100);
        #1; check("R2 irq_out not yet high", 32'(irq_out), 0);
        step();
        check("R2 irq_out high one clock later", 32'(irq_out), 1);
        check("R10 fiq_out unaffected", 32'(fiq_out), 0);
        wr(8'h08, 32'h0000_0003);
        rd(8'h08, d); check("R4 irq mask ORs", d, 32'h0000_0103);
        @(negedge clk);
        src_level = '0;
        #1; check("R2 irq_out held until edge", 32'(irq_out), 1);
        step();
        check("R2 irq_out low after source drop", 32'(irq_out), 0);
    endtask

    task automatic t_fiq();
        logic [31:0] d;
        src_level = 32'h8000_0000;
        wr(8'h28, 32'h8000_0000);
        rd(8'h28, d); check("R4 fiq mask set", d, 32'h8000_0000);
        rd(8'h08, d); check("R10 irq mask unchanged", d, 32'h0000_0103);
        step();
        check("R3 fiq_out high", 32'(fiq_out), 1);
        check("R10 irq_out stays low", 32'(irq_out), 0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(8'h0C, 32'h0000_0100);
        rd(8'h08, d); check("R5 irq mask clear", d, 32'h0000_0003);
        wr(8'h2C, 32'h8000_0000);
        rd(8'h28, d); check("R5 fiq mask clear", d, 32'h0000_0000);
        step();
        check("R3 fiq_out low after mask clear", 32'(fiq_out), 0);
        src_level = '0;
    endtask

    task automatic t_status();
        logic [31:0] d;
        src_level = 32'h0000_0F03;
        wr(8'h28, 32'h0000_0F00);
        rd(8'h00, d); check("R6 irq status", d, 32'h0000_0003);
        rd(8'h20, d); check("R6 fiq status", d, 32'h0000_0F00);
        step();
        check("R2 irq_out on status pattern", 32'(irq_out), 1);
        check("R3 fiq_out on status pattern", 32'(fiq_out), 1);
        src_level = '0;
        step();
    endtask

    task automatic t_soft();
        logic [31:0] d;
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0000_0001);
        wr(8'h10, 32'h0000_0001);
        rd(8'h10, d); check("R7 soft status set", d, 1);
        rd(8'h04, d); check("R1 raw shows soft bit", d, 1);
        #1; check("R7 irq_out not yet high", 32'(irq_out), 0);
        step();
        check("R7 irq_out from soft flag", 32'(irq_out), 1);
        wr(8'h14, 32'h0000_0001);
        rd(8'h10, d); check("R7 soft status clear", d, 0);
        step();
        check("R7 irq_out drops after soft clear", 32'(irq_out), 0);
        src_level = 32'h0000_0001;
        rd(8'h10, d); check("R7 soft status follows source 0", d, 1);
        src_level = '0;
        step();
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R9 irq mask kept", d, 32'h0000_0001);
        rd(8'h28, d); check("R9 fiq mask kept", d, 0);
        rd(8'h10, d); check("R9 soft flag kept", d, 0);
        rd(8'h30, d); check("R9 unused read zero", d, 0);
        rd(8'h0C, d); check("R9 clear offset reads zero", d, 0);
        rd(8'h14, d); check("R9 soft clear reads zero", d, 0);
        step();
        check("R9 irq_out stays low", 32'(irq_out), 0);
        check("R9 fiq_out stays low", 32'(fiq_out), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bus_addr  = 8'hFC;
        bus_wr_en = 1'b0;
        bus_wdata = '0;
        t_reset();
        t_raw();
        t_irq();
        t_fiq();
        t_clear();
        t_status();
        t_soft();
        t_ignored();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule